// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Controller

This block watches the status pins of one removable-card socket and turns pin activity into latched event flags, each qualified by a mask bit, plus two interrupt outputs. The same three shared socket pins carry different meanings depending on the installed card's type, so a card-type input selects how pin edges are decoded. Status-change events latch into flags that software clears by writing ones. A separate level-sensitive functional interrupt passes the card's own request pin through to the host.

Every socket pin is first brought into the clock domain by a synchronizer chain. Only then is it checked for edges. A power-up-done strobe from an external sequencer sets its own flag whatever the card type. If the card-type input changes, every pin-derived flag is dropped, so a stale event read under the old pin meaning cannot stay pending.

Top module: `csc_sock_irq`

## Requirements
- R1: After reset, `flag_q`, `mask_q`, `fen_q`, `csc_irq` and `func_irq` are all zero.
- R2: With card type 2'b00 (memory), any edge on `sock_stat` sets flag bit 0, any edge on `sock_aux` sets flag bit 1, and any edge on `sock_rdy` sets flag bit 2.
- R3: With card type 2'b01 (16-bit I/O), a falling edge on `sock_stat` sets flag bit 0. A rising edge on `sock_stat`, and any edge on `sock_aux` or `sock_rdy`, sets no flag.
- R4: With card type 2'b10 (32-bit bus-master), a rising edge on `sock_stat` sets flag bit 0, any edge on `sock_det[0]` sets bit 1, and any edge on `sock_det[1]` sets bit 2. Falling `sock_stat` and edges on `sock_aux` set no flag.
- R5: With card type 2'b00, 2'b01 or 2'b11 (reserved), an edge on either `sock_det` bit sets flag bit 4.
- R6: A one-cycle `pwr_done` pulse sets flag bit 3 on the next clock edge, for every card type.
- R7: A pin-driven flag is set on the third rising clock edge after the pin changes (two synchronizer stages, then edge detection). It is still clear one cycle earlier.
- R8: Flags latch whatever the mask holds. `csc_irq` is high exactly when some bit is set in both `flag_q` and `mask_q`. `mask_wdata` is loaded when `mask_we` is high.
- R9: Writing a one into a bit of `flag_clr_data` with `flag_clr_we` high clears that flag. If that flag's event arrives in the same cycle, the flag stays set.
- R10: `func_irq` is high when all of these hold: the card type is 2'b01 or 2'b10, the enable bit `fen_q` is set, both `sock_det` bits read low (card present), and `sock_rdy` reads low. It follows `sock_rdy` two cycles behind and is never latched.
- R11: A change on `card_type` clears flag bits 0, 1, 2 and 4 on the next edge and keeps bit 3. A pin event due on that same edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_type | input | 2 | 00 memory, 01 16-bit I/O, 10 bus-master, 11 reserved |
| sock_stat | input | 1 | Shared status pin (battery A / status-change) |
| sock_aux | input | 1 | Shared auxiliary pin (battery B) |
| sock_rdy | input | 1 | Shared ready / interrupt-request pin, request active low |
| sock_det | input | 2 | Card-detect pins, low when a card is seated |
| pwr_done | input | 1 | One-cycle strobe when socket power-up completes |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 5 | Mask write value |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_data | input | 5 | Ones clear the matching flags |
| fen_we | input | 1 | Functional-interrupt enable write strobe |
| fen_wdata | input | 1 | Enable write value |
| flag_q | output | 5 | Latched event flags |
| mask_q | output | 5 | Mask register |
| fen_q | output | 1 | Functional-interrupt enable register |
| csc_irq | output | 1 | Status-change interrupt |
| func_irq | output | 1 | Functional interrupt |

## Verification
A socket pin change driven in cycle c shows up as a flag in cycle c+3 and on `func_irq` in cycle c+2. A register write, a clear, a type change or a `pwr_done` pulse takes effect in cycle c+1. Each driver task records the due cycle along with the expected outputs, and the monitor compares only at the falling clock edge of that exact cycle. An item that has gone past its due cycle counts as a failure. For every pin stimulus there is also an item due in cycle c+2, which confirms the flag is not yet set. Collision cases place a clear or a type change two cycles after a pin change, so that both land on the same edge.

// File: rtl/csc_pkg.sv
// Shared definitions for the socket status-change interrupt controller.
// Assumes one socket, five synchronized pins and a five-bit flag map.
package csc_pkg;
    typedef enum logic [1:0] {
        CARD_MEM  = 2'd0,
        CARD_IO   = 2'd1,
        CARD_BUS  = 2'd2,
        CARD_RSVD = 2'd3
    } card_kind_e;

    // Socket pin positions inside the packed pin vector.
    localparam int PIN_W    = 5;
    localparam int PIN_STAT = 0;
    localparam int PIN_AUX  = 1;
    localparam int PIN_RDY  = 2;
    localparam int PIN_DET0 = 3;
    localparam int PIN_DET1 = 4;

    // Flag positions; software decodes these, so they are fixed.
    localparam int FLAG_W    = 5;
    localparam int FLG_B0    = 0;
    localparam int FLG_B1    = 1;
    localparam int FLG_B2    = 2;
    localparam int FLG_PWR   = 3;
    localparam int FLG_DET16 = 4;

    // Flags whose meaning depends on the card type (cleared on a type change).
    localparam logic [FLAG_W-1:0] PIN_FLAGS = 5'b10111;
endpackage

// File: rtl/csc_pin_sync.sv
// Multi-stage synchronizer plus edge detector for a bundle of socket pins.
// Assumes pins are asynchronous and STAGES >= 2. Edges are suppressed until
// the chain and the history flop hold real samples after reset.
module csc_pin_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall,
    output logic         armed
);
    localparam int            CW     = $clog2(STAGES + 2);
    localparam logic [CW-1:0] ARM_AT = CW'(STAGES + 1);

    logic [CW-1:0] fill_q;

    // Count cycles since reset until the chain and history are filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (fill_q != ARM_AT) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign armed = (fill_q == ARM_AT);

    for (genvar g = 0; g < W; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Shift the pin through the chain and remember the last synced value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pins_in[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl[g]  = chain_q[STAGES-1];
        assign rise[g] = armed & chain_q[STAGES-1] & ~prev_q;
        assign fall[g] = armed & ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/csc_evt_decode.sv
// Maps synchronized pin edges onto flag events according to the card type.
// Pure combinational; assumes rise/fall are already gated by the armed state.
module csc_evt_decode
    import csc_pkg::*;
(
    input  card_kind_e        kind,
    input  logic [PIN_W-1:0]  rise,
    input  logic [PIN_W-1:0]  fall,
    input  logic              pwr_done,
    output logic [FLAG_W-1:0] evt
);
    logic [PIN_W-1:0] chg;
    logic             det_chg;

    assign chg     = rise | fall;
    assign det_chg = chg[PIN_DET0] | chg[PIN_DET1];

    // Select the pin interpretation for the current card type.
    always_comb begin
        evt = '0;
        unique case (kind)
            CARD_MEM: begin
                evt[FLG_B0]    = chg[PIN_STAT];
                evt[FLG_B1]    = chg[PIN_AUX];
                evt[FLG_B2]    = chg[PIN_RDY];
                evt[FLG_DET16] = det_chg;
            end
            CARD_IO: begin
                evt[FLG_B0]    = fall[PIN_STAT];
                evt[FLG_DET16] = det_chg;
            end
            CARD_BUS: begin
                evt[FLG_B0] = rise[PIN_STAT];
                evt[FLG_B1] = chg[PIN_DET0];
                evt[FLG_B2] = chg[PIN_DET1];
            end
            CARD_RSVD: begin
                evt[FLG_DET16] = det_chg;
            end
            default: evt = '0;
        endcase
        evt[FLG_PWR] = pwr_done;
    end
endmodule

// File: rtl/csc_flag_bank.sv
// Event flags with write-one-to-clear, the mask register and the masked OR.
// Assumes a set and a clear of the same bit in one cycle resolve to set;
// a type change wipes the bits selected by PIN_MASK and beats any set.
module csc_flag_bank #(
    parameter int             W        = 5,
    parameter logic [W-1:0]   PIN_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_vec,
    input  logic         type_chg,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] flag_q,
    output logic [W-1:0] mask_q,
    output logic         csc_irq
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;

        if (PIN_MASK[i]) begin : g_pin_bit
            // Pin-derived flag: type change first, then set, then clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (type_chg) begin
                    bit_q <= 1'b0;
                end else if (set_vec[i]) begin
                    bit_q <= 1'b1;
                end else if (clr_we && clr_vec[i]) begin
                    bit_q <= 1'b0;
                end
            end
        end else begin : g_plain_bit
            // Type-independent flag: set wins over clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_vec[i]) begin
                    bit_q <= 1'b1;
                end else if (clr_we && clr_vec[i]) begin
                    bit_q <= 1'b0;
                end
            end
        end

        assign flag_q[i] = bit_q;
    end

    // Load the mask register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    assign csc_irq = |(flag_q & mask_q);
endmodule

// File: rtl/csc_func_gate.sv
// Level-sensitive functional interrupt qualifier.
// Assumes the request pin is active low and card-detect pins read low
// when a card is seated. Memory and reserved card types never pass.
module csc_func_gate
    import csc_pkg::*;
(
    input  logic       armed,
    input  logic       enable,
    input  card_kind_e kind,
    input  logic       req_lvl,
    input  logic [1:0] det_lvl,
    output logic       func_irq
);
    logic kind_ok;
    logic present;

    // Only I/O and bus-master cards have a functional request line.
    always_comb begin
        kind_ok = (kind == CARD_IO) || (kind == CARD_BUS);
    end

    assign present  = (det_lvl == 2'b00);
    assign func_irq = armed & enable & kind_ok & present & ~req_lvl;
endmodule

// File: rtl/csc_sock_irq.sv
// Top of the socket status-change interrupt controller: synchronizes the
// socket pins, decodes edges by card type, latches flags, and drives the
// masked status-change interrupt and the functional interrupt.
// Assumes card_type and the register strobes are synchronous to clk.
module csc_sock_irq
    import csc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        card_type,
    input  logic              sock_stat,
    input  logic              sock_aux,
    input  logic              sock_rdy,
    input  logic [1:0]        sock_det,
    input  logic              pwr_done,
    input  logic              mask_we,
    input  logic [FLAG_W-1:0] mask_wdata,
    input  logic              flag_clr_we,
    input  logic [FLAG_W-1:0] flag_clr_data,
    input  logic              fen_we,
    input  logic              fen_wdata,
    output logic [FLAG_W-1:0] flag_q,
    output logic [FLAG_W-1:0] mask_q,
    output logic              fen_q,
    output logic              csc_irq,
    output logic              func_irq
);
    logic [PIN_W-1:0]  pin_vec;
    logic [PIN_W-1:0]  pin_lvl;
    logic [PIN_W-1:0]  pin_rise;
    logic [PIN_W-1:0]  pin_fall;
    logic              armed;
    logic [FLAG_W-1:0] evt;
    card_kind_e        type_q;
    logic              type_chg;
    logic              unused_lvl;

    assign pin_vec    = {sock_det, sock_rdy, sock_aux, sock_stat};
    assign unused_lvl = ^pin_lvl[PIN_AUX:PIN_STAT];

    // Track the card type so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= card_kind_e'(card_type);
        end else begin
            type_q <= card_kind_e'(card_type);
        end
    end

    assign type_chg = (card_type != type_q);

    // Global functional-interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fen_q <= 1'b0;
        end else if (fen_we) begin
            fen_q <= fen_wdata;
        end
    end

    csc_pin_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pin_vec),
        .lvl     (pin_lvl),
        .rise    (pin_rise),
        .fall    (pin_fall),
        .armed   (armed)
    );

    csc_evt_decode i_decode (
        .kind     (type_q),
        .rise     (pin_rise),
        .fall     (pin_fall),
        .pwr_done (pwr_done),
        .evt      (evt)
    );

    csc_flag_bank #(
        .W        (FLAG_W),
        .PIN_MASK (PIN_FLAGS)
    ) i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (evt),
        .clr_we     (flag_clr_we),
        .clr_vec    (flag_clr_data),
        .type_chg   (type_chg),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .flag_q     (flag_q),
        .mask_q     (mask_q),
        .csc_irq    (csc_irq)
    );

    csc_func_gate i_func (
        .armed    (armed),
        .enable   (fen_q),
        .kind     (type_q),
        .req_lvl  (pin_lvl[PIN_RDY]),
        .det_lvl  (pin_lvl[PIN_DET1:PIN_DET0]),
        .func_irq (func_irq)
    );
endmodule

// File: rtl/csc_sock_irq_chk.sv
// Property checker for csc_sock_irq, attached by bind below.
// Assumes access to the registered card type of the top module.
module csc_sock_irq_chk
    import csc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        card_type,
    input logic [1:0]        type_q,
    input logic              pwr_done,
    input logic              flag_clr_we,
    input logic [FLAG_W-1:0] flag_clr_data,
    input logic [FLAG_W-1:0] flag_q,
    input logic              fen_q,
    input logic              csc_irq,
    input logic              func_irq
);
    logic              tchg;
    logic [FLAG_W-1:0] clr_eff;

    assign tchg    = (card_type != type_q);
    assign clr_eff = (flag_clr_we ? flag_clr_data : '0) | (tchg ? PIN_FLAGS : '0);

    // R6: a power-done strobe sets the power flag on the next edge.
    assert_pwr_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_done |=> flag_q[FLG_PWR]);

    // R8: the status-change interrupt needs at least one pending flag.
    assert_csc_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csc_irq |-> (flag_q != '0));

    // R9: a flag only falls through a clear write or a type change.
    assert_flag_fall_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(flag_q) & ~flag_q) & ~$past(clr_eff)) == '0));

    // R11: a type change empties every pin-derived flag.
    assert_type_wipe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tchg |=> ((flag_q & PIN_FLAGS) == '0));

    // R10: memory and reserved card types never raise a functional interrupt.
    assert_func_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (type_q == CARD_MEM || type_q == CARD_RSVD) |-> !func_irq);

    // R10: the functional interrupt needs the enable bit.
    assert_func_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fen_q |-> !func_irq);
endmodule

bind csc_sock_irq csc_sock_irq_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .card_type     (card_type),
    .type_q        (type_q),
    .pwr_done      (pwr_done),
    .flag_clr_we   (flag_clr_we),
    .flag_clr_data (flag_clr_data),
    .flag_q        (flag_q),
    .fen_q         (fen_q),
    .csc_irq       (csc_irq),
    .func_irq      (func_irq)
);

// File: tb/test_csc_sock_irq.sv
`timescale 1ns/1ps
module test_csc_sock_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] card_type = 2'd0;
    logic [4:0] pv = 5'b00111;   // {det1, det0, rdy, aux, stat}
    logic       pwr_done = 1'b0;
    logic       mask_we = 1'b0;
    logic [4:0] mask_wdata = '0;
    logic       flag_clr_we = 1'b0;
    logic [4:0] flag_clr_data = '0;
    logic       fen_we = 1'b0;
    logic       fen_wdata = 1'b0;
    logic [4:0] flag_q, mask_q;
    logic       fen_q, csc_irq, func_irq;

    int  cyc = 0;
    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;

    // Bench-side model of the register state.
    logic [4:0] m_fl = '0;
    logic [4:0] m_mk = '0;
    logic       m_en = 1'b0;
    logic [1:0] m_t  = 2'd0;

    typedef struct {
        int         due;
        string      req;
        logic [4:0] fl;
        logic [4:0] mk;
        logic       csc;
        logic       fn;
    } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    csc_sock_irq i_csc_sock_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_type     (card_type),
        .sock_stat     (pv[0]),
        .sock_aux      (pv[1]),
        .sock_rdy      (pv[2]),
        .sock_det      (pv[4:3]),
        .pwr_done      (pwr_done),
        .mask_we       (mask_we),
        .mask_wdata    (mask_wdata),
        .flag_clr_we   (flag_clr_we),
        .flag_clr_data (flag_clr_data),
        .fen_we        (fen_we),
        .fen_wdata     (fen_wdata),
        .flag_q        (flag_q),
        .mask_q        (mask_q),
        .fen_q         (fen_q),
        .csc_irq       (csc_irq),
        .func_irq      (func_irq)
    );

    // Expected flag events for a pin change under a card type (R2-R5).
    function automatic logic [4:0] exp_ev(logic [1:0] t, logic [4:0] o, logic [4:0] n);
        logic [4:0] chg = o ^ n;
        logic [4:0] r   = n & ~o;
        logic [4:0] f   = o & ~n;
        logic       dc  = chg[3] | chg[4];
        case (t)
            2'd0:    return {dc, 1'b0, chg[2], chg[1], chg[0]};
            2'd1:    return {dc, 3'b000, f[0]};
            2'd2:    return {2'b00, chg[4], chg[3], r[0]};
            default: return {dc, 4'b0000};
        endcase
    endfunction

    // Expected functional interrupt level (R10).
    function automatic logic exp_fn(logic [1:0] t, logic en, logic [4:0] p);
        return (t == 2'd1 || t == 2'd2) && en && (p[4:3] == 2'b00) && !p[2];
    endfunction

    task automatic push(int due, string req);
        item_t it;
        it.due = due;
        it.req = req;
        it.fl  = m_fl;
        it.mk  = m_mk;
        it.csc = |(m_fl & m_mk);
        it.fn  = exp_fn(m_t, m_en, pv);
        sbq.push_back(it);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Change socket pins; flags due 3 cycles later, none 2 cycles later (R7).
    task automatic do_pins(logic [4:0] nv, string req);
        int c = cyc;
        logic [4:0] ev = exp_ev(m_t, pv, nv);
        pv = nv;
        push(c + 2, {req, "/R7 early"});
        m_fl = m_fl | ev;
        push(c + 3, req);
        wait_n(4);
    endtask

    task automatic do_pwr(logic [4:0] clr, string req);
        int c = cyc;
        pwr_done = 1'b1;
        flag_clr_we = (clr != '0);
        flag_clr_data = clr;
        m_fl = (m_fl & ~clr) | 5'b01000;
        push(c + 1, req);
        wait_n(1);
        pwr_done = 1'b0;
        flag_clr_we = 1'b0;
        flag_clr_data = '0;
        wait_n(1);
    endtask

    task automatic do_clr(logic [4:0] v, string req);
        int c = cyc;
        flag_clr_we = 1'b1;
        flag_clr_data = v;
        m_fl = m_fl & ~v;
        push(c + 1, req);
        wait_n(1);
        flag_clr_we = 1'b0;
        flag_clr_data = '0;
        wait_n(1);
    endtask

    task automatic do_mask(logic [4:0] v, string req);
        int c = cyc;
        mask_we = 1'b1;
        mask_wdata = v;
        m_mk = v;
        push(c + 1, req);
        wait_n(1);
        mask_we = 1'b0;
        wait_n(1);
    endtask

    task automatic do_en(logic e, string req);
        int c = cyc;
        fen_we = 1'b1;
        fen_wdata = e;
        m_en = e;
        push(c + 1, req);
        wait_n(1);
        fen_we = 1'b0;
        wait_n(1);
    endtask

    task automatic do_type(logic [1:0] t, string req);
        int c = cyc;
        card_type = t;
        m_t = t;
        m_fl = m_fl & 5'b01000;
        push(c + 1, req);
        wait_n(2);
    endtask

    // Pin event and a clear of the same flag land on one edge (R9).
    task automatic do_pins_clr(logic [4:0] nv, logic [4:0] clr, string req);
        int c = cyc;
        logic [4:0] ev = exp_ev(m_t, pv, nv);
        pv = nv;
        wait_n(2);
        flag_clr_we = 1'b1;
        flag_clr_data = clr;
        m_fl = (m_fl & ~clr) | ev;
        push(c + 3, req);
        wait_n(1);
        flag_clr_we = 1'b0;
        flag_clr_data = '0;
        wait_n(1);
    endtask

    // Pin event and a type change land on one edge (R11).
    task automatic do_pins_type(logic [4:0] nv, logic [1:0] t, string req);
        int c = cyc;
        pv = nv;
        wait_n(2);
        card_type = t;
        m_t = t;
        m_fl = m_fl & 5'b01000;
        push(c + 3, req);
        wait_n(2);
    endtask

    // Monitor: compare each expected item in its due cycle.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            n_run++;
            if (it.due < cyc) begin
                n_fail++;
                $display("FAIL %s: item missed at cycle %0d (due %0d)", it.req, cyc, it.due);
            end else if (flag_q !== it.fl || mask_q !== it.mk ||
                         csc_irq !== it.csc || func_irq !== it.fn) begin
                n_fail++;
                $display("FAIL %s: got fl=%b mk=%b csc=%b fn=%b, exp fl=%b mk=%b csc=%b fn=%b",
                         it.req, flag_q, mask_q, csc_irq, func_irq,
                         it.fl, it.mk, it.csc, it.fn);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, exp finished run");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(5);
        push(cyc + 1, "R1 reset state");
        wait_n(2);
        n_run++;
        if (fen_q !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got fen_q=%b, exp 0", fen_q);
        end

        // Memory card interpretation.
        do_pins(5'b00110, "R2 stat fall");
        do_clr(5'b00001, "R9 clear bit0");
        do_pins(5'b00111, "R2 stat rise");
        do_pins(5'b00101, "R2 aux edge");
        do_pins(5'b00001, "R2 rdy edge");
        do_mask(5'b00100, "R8 masked bit2 drives csc");
        do_mask(5'b01000, "R8 flags latch, csc low under other mask");
        do_en(1'b1, "R10 memory card no func");
        do_pins(5'b01001, "R5 det0 edge memory");
        do_pins(5'b00001, "R5 det0 back");
        do_pwr(5'b00000, "R6 pwr done");
        do_clr(5'b11111, "R9 clear all");
        do_pwr(5'b01000, "R9 set wins over clear");
        do_clr(5'b01000, "R9 clear pwr");
        do_pins(5'b00101, "R2 rdy rise");
        do_pins_clr(5'b00001, 5'b00100, "R9 pin set wins over clear");
        do_pwr(5'b00000, "R6 pwr before type change");

        // 16-bit I/O interpretation.
        do_type(2'd1, "R11 type change keeps pwr only");
        do_pins(5'b00000, "R3 stat fall");
        do_pins(5'b00001, "R3 stat rise ignored");
        do_pins(5'b00011, "R3 aux ignored");
        do_pins(5'b00111, "R3/R10 rdy high no func");
        do_pins(5'b00011, "R10 rdy low func");
        do_en(1'b0, "R10 enable off");
        do_en(1'b1, "R10 enable on");
        do_pins(5'b10011, "R5/R10 det1 removal");
        do_pins(5'b00011, "R5 det1 back");
        do_clr(5'b11111, "R9 clear all io");

        // Bus-master interpretation.
        do_type(2'd2, "R11 to bus card");
        do_pins(5'b01011, "R4 det0 edge");
        do_pins(5'b11011, "R4 det1 edge");
        do_pins(5'b00011, "R4 det back");
        do_pins(5'b00010, "R4 stat fall ignored");
        do_pins(5'b00011, "R4 stat rise");
        do_pins(5'b00001, "R4 aux ignored");
        do_clr(5'b11111, "R9 clear all bus");
        do_pins_type(5'b01001, 2'd0, "R11 pending event dropped");

        // Reserved type.
        do_type(2'd3, "R11 to reserved");
        do_pins(5'b00001, "R5/R10 reserved det edge");
        do_pwr(5'b00000, "R6 pwr reserved");

        wait_n(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule